// File: doc/BRIEF.md
# CD Data Controller Host Register File

This block is the byte-wide register file through which a host processor programs and watches a CD data controller. The host first loads a 4-bit register index through a dedicated pointer port. After that it issues data reads and data writes, and each access lands on the register the index selects. The same index value names one register on the read side and a different one on the write side. After most accesses the index steps to the next value on its own, so a run of registers can be walked without reloading the pointer.

Some writes and reads do more than move data. A write can start or stop a transfer, acknowledge the end-of-transfer interrupt, or reset the whole file. A read of the last status byte clears the decode interrupt flag and can latch a decode-complete code. The block sends strobes to the data mover: one for a DMA-style transfer start, one for host-port data ready, and one for a forced stop. It takes back a one-cycle end-of-transfer pulse from the mover and raises an interrupt request when that interrupt is enabled. Read data is combinational from the selected register. Every state change is committed on the clock edge of the access.

Top module: `cdc_regfile`

## Requirements
- R1: After reset, the read side returns: index 1 (interface status) 0xFF, index 7 (header byte 3) 0x01, index 10 0x60 and index 11 0x12 (write address 4704), index 12 (status byte 0) 0x80, and 0x00 at every other index. The pointer is 0, busy is low, all strobes are low and the interrupt request is low.
- R2: The read map by index is:
  - 0: command-in
  - 1: interface status
  - 2 and 3: byte count low and high
  - 4 to 7: header bytes 0 to 3
  - 8 and 9: block pointer low and high
  - 10 and 11: write address low and high
  - 12 to 15: status bytes 0 to 3
- R3: An accepted access moves the pointer to index+1. It leaves the pointer unchanged for a read at index 15 and for a write at index 6, 7, 14 or 15.
- R4: The write map by index is:
  - 0: sub-output byte, shown on sub_out
  - 1: interface control
  - 2 and 3: byte count low and high
  - 4 and 5: data address low and high, shown on xfer_addr
  - 6: trigger
  - 7: acknowledge
  - 8 and 9: write address low and high
  - 10, 11 and 14: control bytes 0, 1 and 2, shown on dec_ctrl as {c2,c1,c0}
  - 12 and 13: block pointer low and high
  - 15: soft reset
- R5: A write to index 1 with data bit 1 clear does three things. It clears the byte count and busy. It sets interface-status bit 3 (active-low busy). It pulses xfer_stop for one cycle.
- R6: A write to index 6 while interface-control bit 1 is set has these effects:
  - it clears interface-status bit 3 and sets busy;
  - with dest_mode 2 or 3 it pulses host_ready;
  - with dest_mode 4, 5 or 7 it pulses xfer_start.
- R7: A write to index 6 while interface-control bit 1 is clear changes nothing. With dest_mode 0, 1 or 6 the trigger sets busy but pulses no strobe.
- R8: An xfer_end pulse while busy has these effects:
  - it clears busy and the byte count;
  - it sets interface-status bit 3;
  - if interface-control bit 6 is set, it clears interface-status bit 6 and raises eot_irq (eot_irq is the inverse of that bit).
  A write to index 7 sets that bit again and drops eot_irq.
- R9: A read at index 15 returns the current status byte 3 and sets interface-status bit 5. Status byte 3 then becomes 0x80 if all three of these hold:
  - control-0 bit 7 is set;
  - interface-control bit 5 is set;
  - indices 1, 4 to 9 and 12 to 14 have all been read since the last reset.
- R10: A write to index 15 returns every register, and the record of decode reads, to its reset value. The pointer is left at 15.
- R11: In one cycle the pointer port has priority over a write, and a write has priority over a read. Only the winning operation takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_we | input | 1 | Load the register pointer |
| ptr_wdata | input | 4 | Pointer value to load |
| rd_en | input | 1 | Read access strobe |
| wr_en | input | 1 | Write access strobe |
| wdata | input | 8 | Write data |
| dest_mode | input | 3 | Destination field of the external mode register |
| xfer_end | input | 1 | End-of-transfer pulse from the data mover |
| rdata | output | 8 | Read data of the selected register (combinational) |
| ptr | output | 4 | Current register pointer |
| busy | output | 1 | Transfer in progress |
| xfer_start | output | 1 | One-cycle DMA transfer start strobe |
| host_ready | output | 1 | One-cycle host-port data-ready strobe |
| xfer_stop | output | 1 | One-cycle forced-stop strobe |
| eot_irq | output | 1 | End-of-transfer interrupt request |
| xfer_count | output | 16 | Byte count |
| xfer_addr | output | 16 | Data address |
| dec_ctrl | output | 24 | Control bytes {c2,c1,c0} |
| sub_out | output | 8 | Sub-output byte |

## Verification
A full sequential read from index 0 checks the reset image and the read map together. A sequential write and readback over the same indices shows that read and write decode differently and that the pointer holds at the listed indices. The trigger is tried with transfers disabled, with a host-port destination, with a DMA destination and with an invalid destination. This separates the three strobe outcomes from the no-effect case. The decode latch is exercised once with an incomplete read history and once with a complete one. A final cycle with pointer load, write and read all asserted shows that only the pointer load acts, because a write reaching index 15 would have erased the latched status byte.

// File: rtl/cdc_pkg.sv
package cdc_pkg;
    localparam int PTR_W  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NREG   = 1 << PTR_W;
    localparam int NQUAD  = 4;

    localparam logic [PTR_W-1:0] IX_LAST = PTR_W'(NREG - 1);

    // write-side indices with side effects
    localparam logic [PTR_W-1:0] WIX_IFCTRL = 4'h1;
    localparam logic [PTR_W-1:0] WIX_TRIG   = 4'h6;
    localparam logic [PTR_W-1:0] WIX_ACK    = 4'h7;

    // interface status bits (active low flags)
    localparam int IFS_BUSY_N = 3;
    localparam int IFS_DEC_N  = 5;
    localparam int IFS_EOT_N  = 6;
    // interface control bits
    localparam int IFC_XFER_EN = 1;
    localparam int IFC_DEC_EN  = 5;
    localparam int IFC_EOT_EN  = 6;
    // control-0 decode enable bit
    localparam int C0_DEC_EN = 7;

    localparam logic [NREG-1:0]        DEC_READ_SET = 16'h73F2;
    localparam logic [BYTE_W-1:0]      DEC_DONE_CODE = 8'h80;
    localparam logic [WORD_W-1:0]      WADDR_RST    = WORD_W'(4704);
    localparam logic [NQUAD*BYTE_W-1:0] HEAD_RST    = 32'h0100_0000;
    localparam logic [NQUAD*BYTE_W-1:0] STAT_RST    = 32'h0000_0080;

    typedef struct packed {
        logic [PTR_W-1:0]        ptr;
        logic [BYTE_W-1:0]       comin;
        logic [BYTE_W-1:0]       ifstat;
        logic [BYTE_W-1:0]       ifctrl;
        logic [BYTE_W-1:0]       sbout;
        logic [WORD_W-1:0]       cnt;
        logic [WORD_W-1:0]       dac;
        logic [WORD_W-1:0]       wa;
        logic [WORD_W-1:0]       pt;
        logic [BYTE_W-1:0]       ctrl0;
        logic [BYTE_W-1:0]       ctrl1;
        logic [BYTE_W-1:0]       ctrl2;
        logic [NQUAD*BYTE_W-1:0] head;
        logic [NQUAD*BYTE_W-1:0] stat;
        logic [NREG-1:0]         rdmask;
        logic                    busy;
        logic                    st_dma;
        logic                    st_host;
        logic                    st_stop;
    } regs_t;

    localparam regs_t REGS_RST = '{
        ptr: '0, comin: '0, ifstat: 8'hFF, ifctrl: '0, sbout: '0,
        cnt: '0, dac: '0, wa: WADDR_RST, pt: '0,
        ctrl0: '0, ctrl1: '0, ctrl2: '0,
        head: HEAD_RST, stat: STAT_RST, rdmask: '0,
        busy: 1'b0, st_dma: 1'b0, st_host: 1'b0, st_stop: 1'b0
    };
endpackage

// File: rtl/cdc_ptr_step.sv
module cdc_ptr_step
    import cdc_pkg::*;
#(
    parameter logic [NREG-1:0] HOLD_ON_WR = 16'hC0C0,
    parameter logic [NREG-1:0] HOLD_ON_RD = 16'h8000
) (
    input  logic [PTR_W-1:0] ptr_q,
    input  logic             ptr_we,
    input  logic [PTR_W-1:0] ptr_wdata,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [PTR_W-1:0] ptr_d,
    output logic             do_wr,
    output logic             do_rd
);
    logic hold;

    always_comb begin
        do_wr = !ptr_we && wr_en;
        do_rd = !ptr_we && !wr_en && rd_en;
        hold  = (do_wr && HOLD_ON_WR[ptr_q]) || (do_rd && HOLD_ON_RD[ptr_q]);
        if (ptr_we)
            ptr_d = ptr_wdata;
        else if ((do_wr || do_rd) && !hold)
            ptr_d = ptr_q + PTR_W'(1);
        else
            ptr_d = ptr_q;
    end
endmodule

// File: rtl/cdc_rd_mux.sv
module cdc_rd_mux
    import cdc_pkg::*;
(
    input  logic [PTR_W-1:0]        idx,
    input  logic [BYTE_W-1:0]       comin,
    input  logic [BYTE_W-1:0]       ifstat,
    input  logic [WORD_W-1:0]       cnt,
    input  logic [NQUAD*BYTE_W-1:0] head,
    input  logic [WORD_W-1:0]       pt,
    input  logic [WORD_W-1:0]       wa,
    input  logic [NQUAD*BYTE_W-1:0] stat,
    output logic [BYTE_W-1:0]       rdata
);
    logic [NREG-1:0][BYTE_W-1:0] bank;

    always_comb begin
        bank[0]  = comin;
        bank[1]  = ifstat;
        bank[2]  = cnt[BYTE_W-1:0];
        bank[3]  = cnt[WORD_W-1:BYTE_W];
        bank[8]  = pt[BYTE_W-1:0];
        bank[9]  = pt[WORD_W-1:BYTE_W];
        bank[10] = wa[BYTE_W-1:0];
        bank[11] = wa[WORD_W-1:BYTE_W];
        for (int k = 0; k < NQUAD; k++) begin
            bank[4 + k]  = head[BYTE_W*k +: BYTE_W];
            bank[12 + k] = stat[BYTE_W*k +: BYTE_W];
        end
    end

    assign rdata = bank[idx];
endmodule

// File: rtl/cdc_regfile.sv
module cdc_regfile
    import cdc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ptr_we,
    input  logic [PTR_W-1:0]    ptr_wdata,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic [2:0]          dest_mode,
    input  logic                xfer_end,
    output logic [BYTE_W-1:0]   rdata,
    output logic [PTR_W-1:0]    ptr,
    output logic                busy,
    output logic                xfer_start,
    output logic                host_ready,
    output logic                xfer_stop,
    output logic                eot_irq,
    output logic [WORD_W-1:0]   xfer_count,
    output logic [WORD_W-1:0]   xfer_addr,
    output logic [3*BYTE_W-1:0] dec_ctrl,
    output logic [BYTE_W-1:0]   sub_out
);
    regs_t            s_d, s_q;
    logic [PTR_W-1:0] ptr_nx;
    logic             do_wr, do_rd;
    logic             dec_ready;

    cdc_ptr_step u_ptr (
        .ptr_q    (s_q.ptr),
        .ptr_we   (ptr_we),
        .ptr_wdata(ptr_wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .ptr_d    (ptr_nx),
        .do_wr    (do_wr),
        .do_rd    (do_rd)
    );

    cdc_rd_mux u_mux (
        .idx   (s_q.ptr),
        .comin (s_q.comin),
        .ifstat(s_q.ifstat),
        .cnt   (s_q.cnt),
        .head  (s_q.head),
        .pt    (s_q.pt),
        .wa    (s_q.wa),
        .stat  (s_q.stat),
        .rdata (rdata)
    );

    assign dec_ready = s_q.ctrl0[C0_DEC_EN] && s_q.ifctrl[IFC_DEC_EN] &&
                       ((s_q.rdmask & DEC_READ_SET) == DEC_READ_SET);

    always_comb begin
        s_d         = s_q;
        s_d.ptr     = ptr_nx;
        s_d.st_dma  = 1'b0;
        s_d.st_host = 1'b0;
        s_d.st_stop = 1'b0;

        if (xfer_end && s_q.busy) begin
            s_d.busy              = 1'b0;
            s_d.cnt               = '0;
            s_d.ifstat[IFS_BUSY_N] = 1'b1;
            if (s_q.ifctrl[IFC_EOT_EN])
                s_d.ifstat[IFS_EOT_N] = 1'b0;
        end

        if (do_wr) begin
            unique case (s_q.ptr)
                4'h0: s_d.sbout = wdata;
                4'h1: begin
                    s_d.ifctrl = wdata;
                    if (!wdata[IFC_XFER_EN]) begin
                        s_d.cnt                = '0;
                        s_d.busy               = 1'b0;
                        s_d.ifstat[IFS_BUSY_N] = 1'b1;
                        s_d.st_stop            = 1'b1;
                    end
                end
                4'h2: s_d.cnt[BYTE_W-1:0]      = wdata;
                4'h3: s_d.cnt[WORD_W-1:BYTE_W] = wdata;
                4'h4: s_d.dac[BYTE_W-1:0]      = wdata;
                4'h5: s_d.dac[WORD_W-1:BYTE_W] = wdata;
                4'h6: begin
                    if (s_q.ifctrl[IFC_XFER_EN]) begin
                        s_d.ifstat[IFS_BUSY_N] = 1'b0;
                        s_d.busy               = 1'b1;
                        unique case (dest_mode)
                            3'd2, 3'd3:       s_d.st_host = 1'b1;
                            3'd4, 3'd5, 3'd7: s_d.st_dma  = 1'b1;
                            default: ;
                        endcase
                    end
                end
                4'h7: s_d.ifstat[IFS_EOT_N] = 1'b1;
                4'h8: s_d.wa[BYTE_W-1:0]      = wdata;
                4'h9: s_d.wa[WORD_W-1:BYTE_W] = wdata;
                4'hA: s_d.ctrl0 = wdata;
                4'hB: s_d.ctrl1 = wdata;
                4'hC: s_d.pt[BYTE_W-1:0]      = wdata;
                4'hD: s_d.pt[WORD_W-1:BYTE_W] = wdata;
                4'hE: s_d.ctrl2 = wdata;
                4'hF: begin
                    s_d     = REGS_RST;
                    s_d.ptr = s_q.ptr;
                end
                default: ;
            endcase
        end

        if (do_rd) begin
            s_d.rdmask[s_q.ptr] = 1'b1;
            if (s_q.ptr == IX_LAST) begin
                s_d.ifstat[IFS_DEC_N] = 1'b1;
                if (dec_ready)
                    s_d.stat[(NQUAD-1)*BYTE_W +: BYTE_W] = DEC_DONE_CODE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= REGS_RST;
        else        s_q <= s_d;
    end

    assign ptr        = s_q.ptr;
    assign busy       = s_q.busy;
    assign xfer_start = s_q.st_dma;
    assign host_ready = s_q.st_host;
    assign xfer_stop  = s_q.st_stop;
    assign eot_irq    = !s_q.ifstat[IFS_EOT_N];
    assign xfer_count = s_q.cnt;
    assign xfer_addr  = s_q.dac;
    assign dec_ctrl   = {s_q.ctrl2, s_q.ctrl1, s_q.ctrl0};
    assign sub_out    = s_q.sbout;

    AST_PTR_HOLD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && wr_en && (ptr == 4'h6 || ptr == 4'h7 || ptr == 4'hE || ptr == 4'hF))
        |=> $stable(ptr)); // R3
    AST_PTR_STEP_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && !wr_en && rd_en && ptr != IX_LAST)
        |=> ptr == $past(ptr) + 4'd1); // R3
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> ptr == $past(ptr_wdata)); // R11
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_start, host_ready, xfer_stop})); // R6
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start || host_ready) |-> busy); // R6
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stop |-> (!busy && xfer_count == '0)); // R5
    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && wr_en && ptr == WIX_ACK) |=> !eot_irq); // R8
    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && busy && !ptr_we && !wr_en) |=> (!busy && xfer_count == '0)); // R8
endmodule

// File: tb/cdc_regfile_tb_top.sv
`timescale 1ns/1ps
module cdc_regfile_tb_top;
    localparam int S_RDATA = 0, S_PTR = 1, S_BUSY = 2, S_STRB = 3, S_IRQ = 4,
                   S_CNT = 5, S_ADDR = 6, S_CTRL = 7, S_SUB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_we = 1'b0, rd_en = 1'b0, wr_en = 1'b0, xfer_end = 1'b0;
    logic [3:0]  ptr_wdata = '0;
    logic [7:0]  wdata = '0;
    logic [2:0]  dest_mode = '0;
    logic [7:0]  rdata;
    logic [3:0]  ptr;
    logic        busy, xfer_start, host_ready, xfer_stop, eot_irq;
    logic [15:0] xfer_count, xfer_addr;
    logic [23:0] dec_ctrl;
    logic [7:0]  sub_out;

    cdc_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .dest_mode(dest_mode),
        .xfer_end(xfer_end), .rdata(rdata), .ptr(ptr), .busy(busy),
        .xfer_start(xfer_start), .host_ready(host_ready), .xfer_stop(xfer_stop),
        .eot_irq(eot_irq), .xfer_count(xfer_count), .xfer_addr(xfer_addr),
        .dec_ctrl(dec_ctrl), .sub_out(sub_out)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    due;
        int    sel;
        int    exp;
        string tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int observe(int sel);
        case (sel)
            S_RDATA: return int'(rdata);
            S_PTR:   return int'(ptr);
            S_BUSY:  return int'(busy);
            S_STRB:  return int'({xfer_start, host_ready, xfer_stop});
            S_IRQ:   return int'(eot_irq);
            S_CNT:   return int'(xfer_count);
            S_ADDR:  return int'(xfer_addr);
            S_CTRL:  return int'(dec_ctrl);
            default: return int'(sub_out);
        endcase
    endfunction

    // monitor: compares every due item away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                int    got;
                it  = q.pop_front();
                got = observe(it.sel);
                checks++;
                if (it.due != cyc || got != it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h (sel %0d)",
                             it.tag, got, it.exp, it.sel);
                end
            end
        end
    end

    task automatic expect_now(int sel, int exp, string tag);
        item_t it;
        it.due = cyc; it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic op(bit pwe, logic [3:0] pd, bit wr, logic [7:0] wd, bit rd);
        @(negedge clk);
        ptr_we = pwe; ptr_wdata = pd; wr_en = wr; wdata = wd; rd_en = rd;
        @(posedge clk);
        #1;
        ptr_we = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic set_ptr(logic [3:0] p);
        op(1'b1, p, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic wr(logic [7:0] d);
        op(1'b0, 4'h0, 1'b1, d, 1'b0);
    endtask

    task automatic rd_chk(int exp, string tag);
        @(negedge clk);
        rd_en = 1'b1;
        expect_now(S_RDATA, exp, tag);
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    task automatic end_pulse();
        @(negedge clk);
        xfer_end = 1'b1;
        @(posedge clk);
        #1;
        xfer_end = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int rst_img[16];
        rst_img = '{8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01,
                    8'h00, 8'h00, 8'h60, 8'h12, 8'h80, 8'h00, 8'h00, 8'h00};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        expect_now(S_PTR, 0, "R1 reset pointer");
        expect_now(S_BUSY, 0, "R1 reset busy");
        expect_now(S_STRB, 0, "R1 reset strobes");
        expect_now(S_IRQ, 0, "R1 reset irq");

        // R1 / R2: walk the whole read side from index 0
        set_ptr(4'h0);
        for (int i = 0; i < 16; i++) rd_chk(rst_img[i], $sformatf("R1 R2 reset read idx %0d", i));
        expect_now(S_PTR, 15, "R3 read at last index holds");

        // R4 / R3: write map with holds
        set_ptr(4'h2);
        wr(8'h34); wr(8'h12);
        expect_now(S_CNT, 16'h1234, "R4 byte count");
        expect_now(S_PTR, 4, "R3 step after count");
        wr(8'h78); wr(8'h56);
        expect_now(S_ADDR, 16'h5678, "R4 data address");
        set_ptr(4'h8);
        wr(8'hAB); wr(8'hCD); wr(8'h11); wr(8'h22); wr(8'h44); wr(8'h33);
        wr(8'h55);
        expect_now(S_PTR, 14, "R3 write at index 14 holds");
        expect_now(S_CTRL, 24'h552211, "R4 control bytes");
        set_ptr(4'h0);
        wr(8'h9A);
        expect_now(S_SUB, 8'h9A, "R4 sub-output");
        expect_now(S_PTR, 1, "R3 step after index 0 write");
        set_ptr(4'h8);
        rd_chk(8'h44, "R4 block pointer low");
        rd_chk(8'h33, "R4 block pointer high");
        rd_chk(8'hAB, "R4 write address low");
        rd_chk(8'hCD, "R4 write address high");

        // R7: trigger while disabled
        dest_mode = 3'd5;
        set_ptr(4'h6);
        wr(8'h00);
        expect_now(S_PTR, 6, "R3 trigger index holds");
        expect_now(S_STRB, 0, "R7 disabled trigger no strobe");
        expect_now(S_BUSY, 0, "R7 disabled trigger no busy");
        set_ptr(4'h1);
        rd_chk(8'hFF, "R7 disabled trigger leaves status");

        // R6: DMA destination
        set_ptr(4'h1);
        wr(8'h42);
        expect_now(S_STRB, 0, "R5 enable write gives no stop");
        set_ptr(4'h6);
        wr(8'h00);
        expect_now(S_STRB, 3'b100, "R6 dma start strobe");
        expect_now(S_BUSY, 1, "R6 busy set");
        set_ptr(4'h1);
        rd_chk(8'hF7, "R6 busy flag low in status");

        // R8: end of transfer with interrupt enabled, then acknowledge
        end_pulse();
        expect_now(S_BUSY, 0, "R8 end clears busy");
        expect_now(S_IRQ, 1, "R8 end raises irq");
        expect_now(S_CNT, 0, "R8 end clears count");
        set_ptr(4'h1);
        rd_chk(8'hBF, "R8 status after end");
        set_ptr(4'h7);
        wr(8'h00);
        expect_now(S_IRQ, 0, "R8 ack drops irq");
        expect_now(S_PTR, 7, "R3 ack index holds");

        // R6 host destination, then R5 stop
        dest_mode = 3'd2;
        set_ptr(4'h2);
        wr(8'h10); wr(8'h00);
        set_ptr(4'h6);
        wr(8'h00);
        expect_now(S_STRB, 3'b010, "R6 host ready strobe");
        set_ptr(4'h1);
        wr(8'h40);
        expect_now(S_STRB, 3'b001, "R5 stop strobe");
        expect_now(S_BUSY, 0, "R5 stop clears busy");
        expect_now(S_CNT, 0, "R5 stop clears count");
        set_ptr(4'h1);
        rd_chk(8'hFF, "R5 status after stop");

        // R7 invalid destination; R8 end without interrupt enable
        dest_mode = 3'd6;
        set_ptr(4'h1);
        wr(8'h02);
        set_ptr(4'h6);
        wr(8'h00);
        expect_now(S_STRB, 0, "R7 invalid destination no strobe");
        expect_now(S_BUSY, 1, "R7 invalid destination busy");
        end_pulse();
        expect_now(S_BUSY, 0, "R8 end clears busy (irq disabled)");
        expect_now(S_IRQ, 0, "R8 no irq when disabled");

        // R10: soft reset
        set_ptr(4'hF);
        wr(8'h00);
        expect_now(S_PTR, 15, "R10 pointer stays");
        expect_now(S_CTRL, 0, "R10 control cleared");
        expect_now(S_SUB, 0, "R10 sub-output cleared");
        expect_now(S_ADDR, 0, "R10 data address cleared");
        set_ptr(4'h1);
        rd_chk(8'hFF, "R10 status restored");
        set_ptr(4'hA);
        rd_chk(8'h60, "R10 write address restored");

        // R9: decode latch, incomplete then complete read history
        set_ptr(4'hA);
        wr(8'h80);
        set_ptr(4'h1);
        wr(8'h20);
        set_ptr(4'hF);
        rd_chk(8'h00, "R9 first read of last status");
        rd_chk(8'h00, "R9 incomplete history no latch");
        set_ptr(4'h1);
        rd_chk(8'hFF, "R9 status read");
        set_ptr(4'h4);
        rd_chk(8'h00, "R9 header 0"); rd_chk(8'h00, "R9 header 1");
        rd_chk(8'h00, "R9 header 2"); rd_chk(8'h01, "R9 header 3");
        rd_chk(8'h00, "R9 block ptr low"); rd_chk(8'h00, "R9 block ptr high");
        set_ptr(4'hC);
        rd_chk(8'h80, "R9 status 0"); rd_chk(8'h00, "R9 status 1");
        rd_chk(8'h00, "R9 status 2");
        rd_chk(8'h00, "R9 read returns old value");
        rd_chk(8'h80, "R9 decode code latched");

        // R11: pointer load beats write and read; write beats read
        op(1'b1, 4'h9, 1'b1, 8'h55, 1'b1);
        expect_now(S_PTR, 9, "R11 pointer load wins");
        set_ptr(4'hF);
        rd_chk(8'h80, "R11 write at index 15 suppressed");
        set_ptr(4'h2);
        op(1'b0, 4'h0, 1'b1, 8'h77, 1'b1);
        expect_now(S_CNT, 16'h0077, "R11 write wins over read");
        expect_now(S_PTR, 3, "R11 single step");

        repeat (3) @(posedge clk);
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule